// File: doc/BRIEF.md
# Four-Digit Decimal Event Counter with Window Comparators

This block counts rising edges on an external pulse input in four-digit binary-coded decimal, from 0000 to 9999, and rolls over to 0000 after 9999. The pulse input passes through a synchronizer first, so it may be fully asynchronous to the block clock. Two clear inputs force the running count to zero and hold it there. One is meant for a board-level pin. The other is driven by a control register bit. Either one alone is enough, and they may be held together.

The running count is not compared directly. A one-cycle snapshot strobe copies it into a held value, and sixteen window comparators read only that held value. Each comparator has its own inclusive lower and upper bound, written through a small indexed port. Each comparator drives one bit of the hit word. A rollover flag goes high at the first snapshot taken after the count wraps, and it stays high for exactly one snapshot period.

Top module: `bcd_window_counter`

## Requirements
- R1: Each low-to-high transition of `cnt_in` adds one to the running count, provided the input holds each level for at least two clock cycles. The count changes at no other time except a clear.
- R2: The count is four BCD digits. Digit k occupies bits [4k+3:4k], with digit 0 least significant, and each digit carries into the next (0009 goes to 0010, 0099 goes to 0100).
- R3: Incrementing from 9999 gives 0000. At the first snapshot after that, `wrap_o` goes to 1. It returns to 0 at the following snapshot and changes only at snapshots.
- R4: While `hard_clr` is 1, the running count is held at 0000 and edges on `cnt_in` are discarded.
- R5: `soft_clr` behaves exactly like `hard_clr`. Asserting both at once also holds the count at 0000.
- R6: `count_o` takes the running count only on a cycle with `snap` high. At all other times it holds its value.
- R7: `hit_o[n]` is 1 exactly when lower[n] ≤ `count_o` ≤ upper[n]. Both bounds are inclusive.
- R8: If a pair has lower bound 0000, its hit bit is 1 once the count has been cleared and snapshotted.
- R9: Bounds that are not valid BCD are accepted without any error indication. They are compared as plain 16-bit values (for example, a lower bound of 0x00A0 excludes 0x0099 and includes 0x0100).
- R10: A write with `lim_we` high loads `lim_lo` and `lim_hi` into pair `lim_idx` only. The new bounds act on `hit_o` from the next cycle, with no snapshot needed.
- R11: A pair whose lower bound is greater than its upper bound never sets its hit bit.
- R12: After `rst_n` is released, `count_o` is 0000 and `wrap_o` is 0. Every pair holds lower 9999 and upper 0000, so `hit_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | 1 | Asynchronous pulse input to be counted |
| hard_clr | input | 1 | Level clear from a board pin |
| soft_clr | input | 1 | Level clear from a control register bit |
| snap | input | 1 | Snapshot strobe that copies the running count to `count_o` |
| lim_we | input | 1 | Bound write enable |
| lim_idx | input | 4 | Index of the pair to write |
| lim_lo | input | 16 | Lower bound (BCD) |
| lim_hi | input | 16 | Upper bound (BCD) |
| count_o | output | 16 | Snapshotted count, BCD |
| hit_o | output | 16 | One window-hit bit per pair |
| wrap_o | output | 1 | Rollover flag, one snapshot period long |

## Verification
The bench uses the default parameters: sixteen pairs, four digits and a two-stage synchronizer. With four digits, the full 9999-to-0000 rollover can be reached by driving ten thousand pulses. The bench also drives the digit carries at 0009 and 0099 and both inclusive window edges. Clears are held while pulses arrive. A non-BCD bound is placed between 0099 and 0100 so the raw comparison can be seen at the ports.

// File: rtl/bcd_window_counter.sv
module bcd_window_counter #(
  parameter int NPAIR  = 16,
  parameter int DIGITS = 4,
  parameter int SYNC   = 2,
  parameter int IDXW   = $clog2(NPAIR),
  parameter int VW     = 4 * DIGITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_in,
  input  logic            hard_clr,
  input  logic            soft_clr,
  input  logic            snap,
  input  logic            lim_we,
  input  logic [IDXW-1:0] lim_idx,
  input  logic [VW-1:0]   lim_lo,
  input  logic [VW-1:0]   lim_hi,
  output logic [VW-1:0]   count_o,
  output logic [NPAIR-1:0] hit_o,
  output logic            wrap_o
);

  localparam logic [VW-1:0] ALL_NINES = {DIGITS{4'h9}};

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [VW-1:0]   live_q;
  logic [VW-1:0]   live_inc;
  logic            carry_out;
  logic            wrap_pend_q;
  logic [NPAIR-1:0][VW-1:0] lo_q;
  logic [NPAIR-1:0][VW-1:0] hi_q;

  wire rise   = sync_q[SYNC-1] & ~prev_q;
  wire clr    = hard_clr | soft_clr;
  wire wrap_ev = rise & ~clr & carry_out;

  always_comb begin
    logic c;
    c = 1'b1;
    live_inc = live_q;
    for (int d = 0; d < DIGITS; d++) begin
      if (c) begin
        if (live_q[4*d +: 4] == 4'd9) begin
          live_inc[4*d +: 4] = 4'd0;
        end else begin
          live_inc[4*d +: 4] = live_q[4*d +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    carry_out = c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cnt_in};
      prev_q <= sync_q[SYNC-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       live_q <= '0;
    else if (clr)     live_q <= '0;
    else if (rise)    live_q <= live_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o     <= '0;
      wrap_o      <= 1'b0;
      wrap_pend_q <= 1'b0;
    end else if (snap) begin
      count_o     <= live_q;
      wrap_o      <= wrap_pend_q;
      wrap_pend_q <= wrap_ev;
    end else begin
      wrap_pend_q <= wrap_pend_q | wrap_ev;
    end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= ALL_NINES;
        hi_q[g] <= '0;
      end else if (lim_we && lim_idx == IDXW'(g)) begin
        lo_q[g] <= lim_lo;
        hi_q[g] <= lim_hi;
      end
    end
    assign hit_o[g] = (lo_q[g] <= count_o) && (count_o <= hi_q[g]);
  end

endmodule

// File: rtl/bcd_window_counter_chk.sv
module bcd_window_counter_chk #(
  parameter int NPAIR  = 16,
  parameter int DIGITS = 4,
  parameter int VW     = 4 * DIGITS
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hard_clr,
  input logic                    soft_clr,
  input logic                    snap,
  input logic                    rise,
  input logic [VW-1:0]           live_q,
  input logic [VW-1:0]           count_o,
  input logic                    wrap_o,
  input logic [NPAIR-1:0]        hit_o,
  input logic [NPAIR-1:0][VW-1:0] lo_q,
  input logic [NPAIR-1:0][VW-1:0] hi_q
);

  AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !hard_clr && !soft_clr) |=> $stable(live_q)); // R1

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      live_q[4*d +: 4] <= 4'd9); // R2
  end

  AST_WRAP_AT_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(wrap_o)); // R3

  AST_HARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> live_q == '0); // R4

  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> live_q == '0); // R5

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(count_o)); // R6

  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> count_o == $past(live_q)); // R6

  for (genvar g = 0; g < NPAIR; g++) begin : g_inv
    AST_INVERTED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q[g] > hi_q[g]) |-> !hit_o[g]); // R11
  end

endmodule

bind bcd_window_counter bcd_window_counter_chk #(
  .NPAIR(NPAIR), .DIGITS(DIGITS), .VW(VW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr), .soft_clr(soft_clr),
  .snap(snap), .rise(rise), .live_q(live_q), .count_o(count_o),
  .wrap_o(wrap_o), .hit_o(hit_o), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/bcd_window_counter_tb.sv
module bcd_window_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_in = 1'b0, hard_clr = 1'b0, soft_clr = 1'b0, snap = 1'b0, lim_we = 1'b0;
  logic [3:0]  lim_idx = '0;
  logic [15:0] lim_lo = '0, lim_hi = '0;
  logic [15:0] count_o, hit_o;
  logic        wrap_o;

  int errors = 0, checks = 0;
  int m_live = 0, m_stored = 0;
  bit m_pend = 0, m_wrap = 0;
  logic [15:0] m_lo [16];
  logic [15:0] m_hi [16];

  always #4 clk = ~clk;

  bcd_window_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .hard_clr(hard_clr),
    .soft_clr(soft_clr), .snap(snap), .lim_we(lim_we), .lim_idx(lim_idx),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .count_o(count_o), .hit_o(hit_o),
    .wrap_o(wrap_o)
  );

  function automatic logic [15:0] to_bcd(int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] exp_hits();
    logic [15:0] h, s;
    s = to_bcd(m_stored);
    for (int g = 0; g < 16; g++) h[g] = (m_lo[g] <= s) && (s <= m_hi[g]);
    return h;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_live = 0; m_stored = 0; m_pend = 0; m_wrap = 0;
    for (int g = 0; g < 16; g++) begin m_lo[g] = 16'h9999; m_hi[g] = 16'h0000; end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1; repeat (2) @(negedge clk);
      cnt_in = 1'b0; repeat (2) @(negedge clk);
      if (!hard_clr && !soft_clr) begin
        if (m_live == 9999) begin m_live = 0; m_pend = 1; end
        else m_live++;
      end
    end
  endtask

  task automatic strobe();
    repeat (4) @(negedge clk);
    snap = 1'b1; @(negedge clk); snap = 1'b0;
    m_stored = m_live; m_wrap = m_pend; m_pend = 0;
  endtask

  task automatic write_lim(int idx, logic [15:0] lo, logic [15:0] hi);
    lim_we = 1'b1; lim_idx = 4'(idx); lim_lo = lo; lim_hi = hi;
    @(negedge clk);
    lim_we = 1'b0;
    m_lo[idx] = lo; m_hi[idx] = hi;
  endtask

  task automatic clear_with(bit h, bit s);
    hard_clr = h; soft_clr = s;
    repeat (2) @(negedge clk);
    m_live = 0;
    pulses(5);
    repeat (4) @(negedge clk);
    hard_clr = 1'b0; soft_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R12 count", count_o, 16'h0000);
    check("R12 wrap", {15'b0, wrap_o}, 16'h0000);
    check("R12 hits", hit_o, 16'h0000);
  endtask

  task automatic t_counting();
    pulses(7); strobe();
    check("R1 count 7", count_o, 16'h0007);
    pulses(3);
    repeat (6) @(negedge clk);
    check("R6 held without snap", count_o, 16'h0007);
    strobe();
    check("R2 carry 0009->0010", count_o, 16'h0010);
    pulses(90); strobe();
    check("R2 carry 0099->0100", count_o, to_bcd(m_live));
    check("R2 value 0100", count_o, 16'h0100);
  endtask

  task automatic t_window();
    do_reset();
    write_lim(3, 16'h0005, 16'h0012);
    write_lim(9, 16'h0020, 16'h0010);
    pulses(4); strobe();
    check("R7 below lower", hit_o, exp_hits());
    pulses(1); strobe();
    check("R7 at lower", hit_o, 16'h0008);
    pulses(7); strobe();
    check("R7 at upper", hit_o, 16'h0008);
    pulses(1); strobe();
    check("R7 above upper", hit_o, 16'h0000);
    pulses(3); strobe();
    check("R11 inverted pair at 0016", hit_o, 16'h0000);
    pulses(4); strobe();
    check("R11 inverted pair at 0020", hit_o, exp_hits());
    write_lim(3, 16'h0015, 16'h0025);
    check("R10 new bounds act without snap", hit_o, 16'h0008);
    check("R10 model", hit_o, exp_hits());
  endtask

  task automatic t_clears();
    pulses(6); strobe();
    clear_with(1'b1, 1'b0); strobe();
    check("R4 hard clear holds zero", count_o, 16'h0000);
    pulses(2); strobe();
    check("R4 counts after release", count_o, 16'h0002);
    clear_with(1'b0, 1'b1); strobe();
    check("R5 soft clear holds zero", count_o, 16'h0000);
    pulses(3);
    clear_with(1'b1, 1'b1); strobe();
    check("R5 both clears", count_o, 16'h0000);
  endtask

  task automatic t_zero_lower();
    write_lim(0, 16'h0000, 16'h0003);
    pulses(8);
    clear_with(1'b1, 1'b0); strobe();
    check("R8 zero lower after clear", hit_o[0] ? 16'h1 : 16'h0, 16'h0001);
  endtask

  task automatic t_non_bcd();
    do_reset();
    write_lim(5, 16'h00A0, 16'h0200);
    pulses(99); strobe();
    check("R9 0099 below 00A0", hit_o, 16'h0000);
    pulses(1); strobe();
    check("R9 0100 above 00A0", hit_o, 16'h0020);
  endtask

  task automatic t_wrap();
    do_reset();
    pulses(9999); strobe();
    check("R3 count 9999", count_o, 16'h9999);
    check("R3 no wrap yet", {15'b0, wrap_o}, 16'h0000);
    pulses(1);
    repeat (6) @(negedge clk);
    check("R3 wrap waits for snap", {15'b0, wrap_o}, 16'h0000);
    strobe();
    check("R3 rolled to 0000", count_o, 16'h0000);
    check("R3 wrap set", {15'b0, wrap_o}, {15'b0, m_wrap});
    pulses(2);
    check("R3 wrap held between snaps", {15'b0, wrap_o}, 16'h0001);
    strobe();
    check("R3 wrap dropped", {15'b0, wrap_o}, 16'h0000);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_counting();
        t_window();
        t_clears();
        t_zero_lower();
        t_non_bcd();
        t_wrap();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule